// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Slave Address Filtering

This block receives asynchronous serial frames on a single input line and delivers each accepted byte to a small register file. It supports an 8-data-bit frame and a 9-data-bit frame. Each bit is oversampled 16 times, and the receiver takes a three-sample majority vote at the middle of the bit. A missing stop bit raises a sticky framing-error flag. The receive-ready flag can rise either after the last data bit or at the stop bit.

On multi-drop links, a host sends address frames with the ninth bit set. With multiprocessor filtering on, a node takes such a frame only when the address matches its own masked address or its broadcast address. It drops data frames whose ninth bit is clear. The oversampling tick comes from an external pulse input or from an internal divider. The 9-bit fixed-rate mode uses a second fixed divider. An optional half-rate stage can be bypassed to double the baud rate.

Software uses a byte-wide register interface with a select, a write strobe and a combinational read path. It clears the ready flag after it reads the byte.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset all five registers read 00h and `rx_irq` is 0.
- R2: Data arrives LSB first. The mode field is CTRL[7:6] (when FE access is off) and CTRL[6]. Mode 01 takes 8 data bits and loads the BIT9 flag (CTRL[2]) with 0. Modes 10 and 11 take 9 data bits and put the ninth into BIT9. Mode 00 receives nothing.
- R3: Each bit is decided by the majority of samples 7, 8 and 9 of its 16 samples. A low on the line that is not confirmed by the start-bit vote is dropped, and the search for a start bit resumes.
- R4: With AUX[6]=0, the ready flag (CTRL[0], also `rx_irq`) rises after the vote on the last data bit. With AUX[6]=1, it rises at the stop-bit vote.
- R5: A stop bit voted low sets the framing-error flag. Later frames with valid stop bits leave the flag set. Only a CTRL write with bit 7 = 0 while AUX[6]=1 clears it.
- R6: CTRL[7] reads and writes the mode high bit when AUX[6]=0, and the framing-error flag when AUX[6]=1. A write reaches only the selected one.
- R7: While the ready flag is set, a new frame leaves DATA, BIT9 and the flag unchanged.
- R8: In modes 10/11 with CTRL[5]=1, a frame with ninth bit 0 is ignored. A frame with ninth bit 1 is taken only on an address hit (R9 or R10).
- R9: Address hit: every received bit where MASK is 1 equals the matching ADDR bit. MASK=FFh gives an exact compare.
- R10: Broadcast hit: every received bit where (ADDR|MASK) is 1 is 1. FFh therefore reaches every node.
- R11: In modes 01/11 the base tick is `ext_tick` (AUX[0]=1) or one pulse every INT_DIV clocks (AUX[0]=0). Mode 10 uses one pulse every FIX_DIV clocks. With AUX[7]=0, every second base tick is an oversample tick. With AUX[7]=1, every base tick is one.
- R12: With CTRL[4]=0, no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| ext_tick | input | 1 | External base-rate pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 CTRL, 1 DATA, 2 AUX, 3 ADDR, 4 MASK |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of selected register |
| rx_irq | output | 1 | Ready flag |

## Verification
The address filter is driven with random node addresses and masks (exact, single don't-care bit, all don't-care, random). Each frame carries the exact address, an address off by one don't-care bit, FFh, the broadcast value or a random byte. This pattern set separates the masked compare from the broadcast compare and from plain acceptance. Directed frames cover three things. First, a bad stop bit followed by a good frame separates a sticky FE flag from one that tracks the last frame. Second, a short low pulse separates the majority vote from single-sample start detection. Third, reading the ready flag early in the stop bit separates the two ready-timing options. The frame timing rests on the clock-source and doubling settings: a wrong tick source or rate mis-samples the byte.

// File: rtl/uart_rx_pkg.sv
// Shared types for the address-filtering serial receiver.
// Assumes: register select is 3 bits wide.
package uart_rx_pkg;
    typedef enum logic [2:0] {
        SEL_CTRL = 3'd0,
        SEL_DATA = 3'd1,
        SEL_AUX  = 3'd2,
        SEL_ADDR = 3'd3,
        SEL_MASK = 3'd4
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rx_state_e;

    localparam int OVS = 16;
endpackage

// File: rtl/uart_rx_baud.sv
// Oversample tick generator. It picks a base tick (external pulse, internal
// divider or fixed divider) and then optionally halves it.
// Assumes: INT_DIV and FIX_DIV are at least 2.
module uart_rx_baud #(
    parameter int INT_DIV = 3,
    parameter int FIX_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_tick,
    input  logic use_ext,
    input  logic fixed_sel,
    input  logic dbl,
    output logic s_tick
);
    localparam int IW = $clog2(INT_DIV);
    localparam int FW = $clog2(FIX_DIV);

    logic [IW-1:0] int_cnt;
    logic [FW-1:0] fix_cnt;
    logic int_tk, fix_tk, base, half;

    assign int_tk = (int_cnt == IW'(INT_DIV - 1));
    assign fix_tk = (fix_cnt == FW'(FIX_DIV - 1));
    assign base   = fixed_sel ? fix_tk : (use_ext ? ext_tick : int_tk);

    // Free-running internal and fixed dividers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_cnt <= '0;
            fix_cnt <= '0;
        end else begin
            int_cnt <= int_tk ? '0 : int_cnt + 1'b1;
            fix_cnt <= fix_tk ? '0 : fix_cnt + 1'b1;
        end
    end

    // Half-rate stage and registered oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half   <= 1'b0;
            s_tick <= 1'b0;
        end else begin
            half   <= half ^ base;
            s_tick <= base && (dbl || half);
        end
    end

    a_r11_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tick && !dbl) |=> !s_tick);
endmodule

// File: rtl/uart_rx_shift.sv
// Bit sampler and frame assembler. It finds the start bit, votes samples
// 7..9 of each bit and shifts the data in LSB first. It pulses data_ev
// after the last data bit and stop_ev at the stop bit.
// Assumes: s_tick is a one-cycle pulse at 16x the bit rate.
module uart_rx_shift
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       en,
    input  logic       nine,
    input  logic       s_tick,
    output logic       data_ev,
    output logic       stop_ev,
    output logic       stop_ok,
    output logic [7:0] frm_byte,
    output logic       frm_ninth
);
    rx_state_e  state;
    logic [1:0] sync;
    logic       rx_s;
    logic [3:0] scnt, bidx, last;
    logic [1:0] votes;
    logic       vote;
    logic [8:0] shreg, nx;

    assign rx_s = sync[1];
    assign last = nine ? 4'd9 : 4'd8;
    assign vote = (votes[1] & votes[0]) | (votes[1] & rx_s) | (votes[0] & rx_s);
    assign nx   = {vote, shreg[8:1]};

    // Two-flop synchroniser on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    // Frame state machine with sample counter and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            scnt      <= '0;
            bidx      <= '0;
            votes     <= '0;
            shreg     <= '0;
            data_ev   <= 1'b0;
            stop_ev   <= 1'b0;
            stop_ok   <= 1'b0;
            frm_byte  <= '0;
            frm_ninth <= 1'b0;
        end else begin
            data_ev <= 1'b0;
            stop_ev <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
            end else if (s_tick) begin
                case (state)
                    ST_IDLE: if (!rx_s) begin
                        state <= ST_RUN;
                        scnt  <= 4'd1;
                        bidx  <= '0;
                    end
                    ST_RUN: begin
                        scnt <= scnt + 1'b1;
                        if (scnt == 4'd7 || scnt == 4'd8) votes <= {votes[0], rx_s};
                        if (scnt == 4'd9) begin
                            if (bidx == 4'd0) begin
                                if (vote) state <= ST_IDLE;
                            end else if (bidx <= last) begin
                                shreg <= nx;
                                if (bidx == last) begin
                                    data_ev   <= 1'b1;
                                    frm_byte  <= nine ? nx[7:0] : nx[8:1];
                                    frm_ninth <= nine & nx[8];
                                end
                            end else begin
                                stop_ev <= 1'b1;
                                stop_ok <= vote;
                                state   <= ST_IDLE;
                            end
                        end
                        if (scnt == 4'd15) bidx <= bidx + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    a_r4_events_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_ev && stop_ev));
    a_r3_stop_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        data_ev |=> !stop_ev);
endmodule

// File: rtl/uart_rx_filter.sv
// Acceptance decision for a finished frame: ready-flag blocking, plus the
// multiprocessor address filter with a masked hit and a broadcast hit.
// Assumes: purely combinational, evaluated when a frame event fires.
module uart_rx_filter (
    input  logic       ri,
    input  logic       nine,
    input  logic       multi,
    input  logic [7:0] rx_byte,
    input  logic       rx_ninth,
    input  logic [7:0] addr,
    input  logic [7:0] mask,
    output logic       accept
);
    logic [7:0] bc;
    logic       given_hit, bcast_hit;

    // Compute address hits and the final accept.
    always_comb begin
        bc        = addr | mask;
        given_hit = (((rx_byte ^ addr) & mask) == 8'h00);
        bcast_hit = (((~rx_byte) & bc) == 8'h00);
        if (ri)                   accept = 1'b0;
        else if (!(nine && multi)) accept = 1'b1;
        else                      accept = rx_ninth && (given_hit || bcast_hit);
    end
endmodule

// File: rtl/uart_addr_rx.sv
// Top: register file, mode decode and load control for the serial
// receiver with slave address filtering.
// Assumes: reads are combinational on reg_sel; writes on reg_wr.
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int INT_DIV = 3,
    parameter int FIX_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       ext_tick,
    input  logic       reg_wr,
    input  logic [2:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       rx_irq
);
    logic       sm0, sm1, multi, rxen, bit9, ri, fe;
    logic       dbl, fesel, clksrc;
    logic [7:0] data_q, addr_q, mask_q;
    logic       nine, en, s_tick, accept, load_go, wr_ctrl;
    logic       data_ev, stop_ev, stop_ok, frm_ninth;
    logic [7:0] frm_byte;

    assign nine    = sm0;
    assign en      = rxen && (sm0 || sm1);
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign load_go = (fesel ? stop_ev : data_ev) && accept;
    assign rx_irq  = ri;

    uart_rx_baud #(.INT_DIV(INT_DIV), .FIX_DIV(FIX_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .use_ext(clksrc),
        .fixed_sel(sm0 && !sm1), .dbl(dbl), .s_tick(s_tick));

    uart_rx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .en(en), .nine(nine),
        .s_tick(s_tick), .data_ev(data_ev), .stop_ev(stop_ev),
        .stop_ok(stop_ok), .frm_byte(frm_byte), .frm_ninth(frm_ninth));

    uart_rx_filter u_filt (
        .ri(ri), .nine(nine), .multi(multi), .rx_byte(frm_byte),
        .rx_ninth(frm_ninth), .addr(addr_q), .mask(mask_q), .accept(accept));

    // Control/status register with shared bit 7 and hardware load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sm0, sm1, multi, rxen, bit9, ri, fe} <= '0;
            data_q <= '0;
        end else begin
            if (stop_ev && !stop_ok) fe <= 1'b1;
            if (wr_ctrl) begin
                sm1   <= reg_wdata[6];
                multi <= reg_wdata[5];
                rxen  <= reg_wdata[4];
                bit9  <= reg_wdata[2];
                ri    <= reg_wdata[0];
                if (fesel) begin
                    if (!reg_wdata[7]) fe <= 1'b0;
                end else begin
                    sm0 <= reg_wdata[7];
                end
            end else if (load_go) begin
                data_q <= frm_byte;
                bit9   <= nine & frm_ninth;
                ri     <= 1'b1;
            end
        end
    end

    // Auxiliary, address and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {dbl, fesel, clksrc} <= '0;
            addr_q <= '0;
            mask_q <= '0;
        end else if (reg_wr) begin
            case (reg_sel)
                SEL_AUX:  {dbl, fesel, clksrc} <= {reg_wdata[7], reg_wdata[6], reg_wdata[0]};
                SEL_ADDR: addr_q <= reg_wdata;
                SEL_MASK: mask_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {fesel ? fe : sm0, sm1, multi, rxen, 1'b0, bit9, 1'b0, ri};
            SEL_DATA: reg_rdata = data_q;
            SEL_AUX:  reg_rdata = {dbl, fesel, 5'b0, clksrc};
            SEL_ADDR: reg_rdata = addr_q;
            SEL_MASK: reg_rdata = mask_q;
            default:  reg_rdata = 8'h00;
        endcase
    end

    a_r7_ready_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ri && !wr_ctrl) |=> (ri && $stable(data_q)));
    a_r5_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fe && !(wr_ctrl && fesel && !reg_wdata[7])) |=> fe);
    a_r8_data_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_ev || stop_ev) && multi && nine && !frm_ninth && !wr_ctrl) |=> (ri == $past(ri)));
endmodule

// File: tb/sim_uart_addr_rx.sv
module sim_uart_addr_rx;
    localparam int INT_DIV = 3;
    localparam int FIX_DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       ext_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_irq;

    int tests = 0;
    int fails = 0;
    int ext_per = 5;
    int bitclk = 48;
    bit done = 1'b0;

    uart_addr_rx #(.INT_DIV(INT_DIV), .FIX_DIV(FIX_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .ext_tick(ext_tick),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .rx_irq(rx_irq));

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            repeat (ext_per - 1) @(negedge clk);
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    function automatic int bit_period(input int mode, input bit ext, input bit dbl);
        int base;
        base = (mode == 2) ? FIX_DIV : (ext ? ext_per : INT_DIV);
        return 16 * base * (dbl ? 1 : 2);
    endfunction

    function automatic bit exp_accept(input bit nine, input bit multi, input bit n9,
                                      input logic [7:0] b, input logic [7:0] a,
                                      input logic [7:0] m);
        logic [7:0] bc;
        bc = a | m;
        if (!(nine && multi)) return 1'b1;
        return n9 && ((((b ^ a) & m) == 8'h00) || ((b & bc) == bc));
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends start, data bits LSB first, optional ninth, stop, then idle.
    task automatic send(input bit nine, input logic [8:0] d, input bit stopv);
        rxd = 1'b0; hold(bitclk);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rxd = d[i]; hold(bitclk);
        end
        rxd = stopv; hold(bitclk);
        rxd = 1'b1; hold(bitclk);
    endtask

    // Same frame, but samples the ready flag a quarter into the stop bit.
    task automatic send_peek(input logic [7:0] d, output logic early);
        rxd = 1'b0; hold(bitclk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; hold(bitclk);
        end
        rxd = 1'b1; hold(bitclk / 4);
        #1 early = rx_irq;
        hold(bitclk - bitclk / 4);
        hold(bitclk);
    endtask

    initial begin
        logic [7:0] r;
        logic early;
        hold(4);
        rst_n = 1'b1;
        hold(2);

        // R1 reset state
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), r);
            check("R1 reset reg", r, 0);
        end
        check("R1 reset irq", rx_irq, 0);

        // R12 receiver disabled: mode 01, RXEN=0
        wr(3'd2, 8'h80);               // dbl=1, internal divider
        bitclk = bit_period(1, 0, 1);
        wr(3'd0, 8'h40);
        send(0, 9'h0A5, 1);
        check("R12 no rx when disabled", rx_irq, 0);

        // R2 mode 01, 8 bits, BIT9 cleared on load
        wr(3'd0, 8'h54);               // set BIT9 by software first
        send(0, 9'h0A5, 1);
        rd(3'd1, r); check("R2 mode1 data", r, 8'hA5);
        rd(3'd0, r); check("R2 mode1 bit9 zero", r[2], 0);
        check("R2 mode1 irq", rx_irq, 1);

        // R7 ready flag blocks a second frame
        send(0, 9'h03C, 1);
        rd(3'd1, r); check("R7 data kept", r, 8'hA5);
        check("R7 irq kept", rx_irq, 1);

        // R3 false start is dropped, next frame still received
        wr(3'd0, 8'h50);
        rxd = 1'b0; hold(bitclk / 8); rxd = 1'b1; hold(2 * bitclk);
        check("R3 false start no irq", rx_irq, 0);
        send(0, 9'h0C3, 1);
        rd(3'd1, r); check("R3 frame after glitch", r, 8'hC3);

        // R4 ready timing with FE access off vs on
        wr(3'd0, 8'h50);
        send_peek(8'h11, early);
        check("R4 early ready fesel0", early, 1);
        wr(3'd2, 8'hC0);               // fesel=1, dbl=1
        wr(3'd0, 8'h50);               // bit7 write clears FE
        send_peek(8'h22, early);
        check("R4 ready waits for stop fesel1", early, 0);
        check("R4 ready at stop", rx_irq, 1);

        // R5 FE sticky; R6 bit7 alias
        wr(3'd0, 8'h50);
        send(0, 9'h055, 0);
        rd(3'd0, r); check("R5 fe set on low stop", r[7], 1);
        wr(3'd0, 8'hD0);               // write 1 to FE: leaves it, clears RI
        send(0, 9'h066, 1);
        rd(3'd0, r); check("R5 fe sticky after good frame", r[7], 1);
        wr(3'd0, 8'h50);
        rd(3'd0, r); check("R5 fe cleared by software", r[7], 0);
        wr(3'd2, 8'h80);               // fesel=0: bit7 shows mode high bit
        rd(3'd0, r); check("R6 bit7 is mode bit", r[7], 0);
        wr(3'd0, 8'hD0);               // mode 11
        wr(3'd2, 8'hC0);
        rd(3'd0, r); check("R6 bit7 shows fe", r[7], 0);
        wr(3'd2, 8'h80);
        rd(3'd0, r); check("R6 mode bit written", r[7], 1);

        // R2 mode 11, 9 bits, ninth into BIT9
        wr(3'd0, 8'hD0);
        send(1, 9'h1E7, 1);
        rd(3'd1, r); check("R2 mode3 data", r, 8'hE7);
        rd(3'd0, r); check("R2 mode3 bit9", r[2], 1);

        // R11 mode 10 fixed divider, half rate
        wr(3'd2, 8'h00);
        bitclk = bit_period(2, 0, 0);
        wr(3'd0, 8'h90);
        send(1, 9'h03B, 1);
        rd(3'd1, r); check("R11 mode2 fixed rate data", r, 8'h3B);
        rd(3'd0, r); check("R11 mode2 bit9", r[2], 0);

        // R11 mode 01 external tick, half rate
        wr(3'd2, 8'h01);
        bitclk = bit_period(1, 1, 0);
        wr(3'd0, 8'h50);
        send(0, 9'h096, 1);
        rd(3'd1, r); check("R11 external tick data", r, 8'h96);

        // R8 R9 R10 random address filtering in mode 11
        void'($urandom(32'd4321));
        wr(3'd2, 8'h80);
        bitclk = bit_period(3, 0, 1);
        for (int k = 0; k < 24; k++) begin
            logic [7:0] a, m, b, prev;
            bit n9, ex;
            int pick;
            a = 8'($urandom);
            pick = $urandom % 4;
            m = (pick == 0) ? 8'hFF : (pick == 1) ? 8'hFB : (pick == 2) ? 8'h00 : 8'($urandom);
            pick = $urandom % 5;
            b = (pick == 0) ? a : (pick == 1) ? (a ^ 8'h04) : (pick == 2) ? 8'hFF :
                (pick == 3) ? (a | m) : 8'($urandom);
            n9 = (k < 4) ? 1'b0 : 1'($urandom);
            wr(3'd3, a);
            wr(3'd4, m);
            wr(3'd0, 8'hF0);           // mode 11, multi on, RI cleared
            rd(3'd1, prev);
            send(1, {n9, b}, 1);
            ex = exp_accept(1, 1, n9, b, a, m);
            check("R8 R9 R10 accept", rx_irq, ex);
            rd(3'd1, r);
            check("R8 R9 R10 data", r, ex ? b : prev);
        end

        // R10 directed: FFh reaches exact-match node
        wr(3'd3, 8'h21); wr(3'd4, 8'hFF); wr(3'd0, 8'hF0);
        send(1, 9'h1FF, 1);
        check("R10 broadcast FF", rx_irq, 1);
        // R9 directed: mask FB ignores bit 2
        wr(3'd3, 8'h21); wr(3'd4, 8'hFB); wr(3'd0, 8'hF0);
        send(1, 9'h125, 1);
        check("R9 masked hit", rx_irq, 1);
        wr(3'd0, 8'hF0);
        send(1, 9'h123, 1);
        check("R9 masked miss", rx_irq, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule